// File: doc/BRIEF.md
# Triggered Strip Hit Buffer and Sparsifier

This block is the digital back end of a strip readout chip that only ships data on request. Every strip channel presents a hit strobe with a small amplitude code. The block stamps each hit with a free-running, wrapping timestamp and parks it in a short per-strip buffer. Nothing leaves the chip until a trigger arrives carrying a timestamp of interest.

On a trigger, a sparsifier walks the strips in ascending order. It emits one word for each buffered hit whose timestamp lies inside a programmable acquisition window that ends at the trigger timestamp. The hit list is closed with an end-of-event marker. Triggers that come in while a readout is running wait in a small queue. Reading a hit does not release it, so a later trigger whose window overlaps can see it again. Buffer entries are released only when they have aged past a fixed limit, which covers the maximum trigger latency plus the window.

The timestamp advances once every `TICK_DIV` readout clocks, so one clock drives both functions, with the timestamp rate a fixed fraction of the readout rate. All timestamp comparisons are taken modulo the counter range.

Top module: `tsb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld`, `out_eoe` and `overflow` are low and `ts_now` is 0.
- R2: `ts_now` is a 9-bit counter that rises by one every `TICK_DIV` (default 2) clocks and wraps from 511 to 0.
- R3: For a trigger with timestamp T, a buffered hit with timestamp H is emitted exactly when (T − H) mod 512 < `cfg_win`. No hit is ever emitted without a trigger.
- R4: A data word has `out_eoe`=0. Its 20-bit `out_word` holds the strip index in [19:13], the hit timestamp in [12:4] and the amplitude in [3:0]. Within one event the words come in ascending strip order.
- R5: Every trigger's list ends with one marker word: `out_eoe`=1, `out_vld`=1, strip and amplitude fields 0, and the timestamp field equal to the trigger timestamp. The marker is sent even when no hit matches.
- R6: Up to `TQ_DEPTH` (4) triggers are held while a readout runs, and they are served in arrival order.
- R7: A buffered hit is released once (`ts_now` − H) mod 512 exceeds `AGE_LIM` (330) ticks. A released hit is never emitted, and its slot can take a new hit.
- R8: A hit on a strip whose `DEPTH` (4) slots are all occupied is dropped. It sets `overflow`, which stays high until reset.
- R9: Reading out does not release a hit, so one hit is emitted once for every trigger whose window covers it.
- R10: A new hit goes into the lowest-numbered free slot of its strip. Within a strip, words leave in slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; the timestamp is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | NSTRIP | One hit strobe per strip |
| hit_amp | input | NSTRIP*4 | Amplitude code per strip; strip s uses bits [4s+3:4s] |
| cfg_win | input | 9 | Acquisition window width in timestamp ticks |
| trig_vld | input | 1 | Trigger strobe |
| trig_ts | input | 9 | Timestamp carried by the trigger |
| ts_now | output | 9 | Current timestamp |
| out_vld | output | 1 | Output word valid |
| out_eoe | output | 1 | Marks the end-of-event word |
| out_word | output | 20 | Sparsified hit word or marker |
| overflow | output | 1 | Sticky flag set by a dropped hit |

## Verification
A hit strobe driven before a rising edge is stored at that edge and carries the `ts_now` value seen just before it. A dropped hit raises `overflow` one edge later, so the bench reads both at the next falling edge. A trigger enters the queue at one edge and is popped at the next. Scanning then takes one cycle per strip plus one per extra hit on a strip, and the marker follows the scan by one cycle, so the bench gathers words at falling edges into a stream and compares that stream in order with a list built from its own model once the expected count has arrived. Aging is checked by waiting more than `AGE_LIM` ticks and then observing both the missing words and the absence of overflow when the freed slots are refilled.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  parameter int TS_W  = 9;
  parameter int AMP_W = 4;

  typedef logic [TS_W-1:0]  ts_t;
  typedef logic [AMP_W-1:0] amp_t;

  // modulo distance from an earlier stamp to a later one
  function automatic ts_t ts_age(ts_t later, ts_t earlier);
    return later - earlier;
  endfunction

  function automatic logic in_window(ts_t trig, ts_t hit, ts_t win);
    return ts_age(trig, hit) < win;
  endfunction

  function automatic logic is_stale(ts_t now, ts_t hit, int unsigned lim);
    return 32'(ts_age(now, hit)) > lim;
  endfunction
endpackage

// File: rtl/tsb_tsgen.sv
module tsb_tsgen
  import tsb_pkg::*;
#(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output ts_t  ts_now,
  output logic ts_tick
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_q;

  assign ts_tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      ts_now <= '0;
    end else if (ts_tick) begin
      div_q  <= '0;
      ts_now <= ts_now + TS_W'(1);
    end else begin
      div_q  <= div_q + DW'(1);
    end
  end

  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_tick |=> ts_now == $past(ts_now) + TS_W'(1));
  p_ts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_tick |=> $stable(ts_now));
endmodule

// File: rtl/tsb_strip.sv
module tsb_strip
  import tsb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int AGE_LIM = 330
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_in,
  input  amp_t                    amp_in,
  input  ts_t                     ts_now,
  input  ts_t                     sel_ts,
  input  ts_t                     win,
  output logic [DEPTH-1:0]        hit_match,
  output logic [DEPTH*TS_W-1:0]   ent_ts_flat,
  output logic [DEPTH*AMP_W-1:0]  ent_amp_flat,
  output logic                    drop
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] stale;
  logic [DEPTH-1:0] free_sel;
  ts_t              ets  [DEPTH];
  amp_t             eamp [DEPTH];

  always_comb begin
    free_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      stale[i]     = vld[i] & is_stale(ts_now, ets[i], AGE_LIM);
      hit_match[i] = vld[i] & in_window(sel_ts, ets[i], win);
      ent_ts_flat[i*TS_W +: TS_W]    = ets[i];
      ent_amp_flat[i*AMP_W +: AMP_W] = eamp[i];
    end
  end

  assign drop = hit_in & (&vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stale[i])                    vld[i] <= 1'b0;
        else if (hit_in && free_sel[i])  vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_in && free_sel[i]) begin
        ets[i]  <= ts_now;
        eamp[i] <= amp_in;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_age_chk
    // R7: no occupied slot survives far beyond the age limit
    p_age_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |-> 32'(ts_age(ts_now, ets[g])) <= AGE_LIM + 2);
  end
endmodule

// File: rtl/tsb_trigq.sv
module tsb_trigq
  import tsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  ts_t  push_ts,
  input  logic pop,
  output logic empty,
  output ts_t  head_ts
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ts_t           mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, wr_en, rd_en;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_en   = push & !full;
  assign rd_en   = pop & !empty;
  assign head_ts = mem[rd_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= nxt(wr_q);
      if (rd_en) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= push_ts;
  end

  p_tq_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_tq_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/tsb_top.sv
module tsb_top
  import tsb_pkg::*;
#(
  parameter int NSTRIP   = 128,
  parameter int DEPTH    = 4,
  parameter int TQ_DEPTH = 4,
  parameter int TICK_DIV = 2,
  parameter int AGE_LIM  = 330
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NSTRIP-1:0]                    hit_vld,
  input  logic [NSTRIP*AMP_W-1:0]              hit_amp,
  input  logic [TS_W-1:0]                      cfg_win,
  input  logic                                 trig_vld,
  input  logic [TS_W-1:0]                      trig_ts,
  output logic [TS_W-1:0]                      ts_now,
  output logic                                 out_vld,
  output logic                                 out_eoe,
  output logic [$clog2(NSTRIP)+TS_W+AMP_W-1:0] out_word,
  output logic                                 overflow
);
  localparam int SA_W   = $clog2(NSTRIP);
  localparam int SL_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EOE} scan_st_t;

  scan_st_t                 state_q;
  logic                     ts_tick;
  logic [SA_W-1:0]          strip_q;
  logic [DEPTH-1:0]         done_q;
  ts_t                      sel_ts;
  logic                     tq_empty, tq_pop;
  ts_t                      tq_head;
  logic [NSTRIP-1:0]        drop_v;
  logic [DEPTH-1:0]         mask_a [NSTRIP];
  logic [DEPTH*TS_W-1:0]    ts_a   [NSTRIP];
  logic [DEPTH*AMP_W-1:0]   amp_a  [NSTRIP];
  logic [DEPTH-1:0]         cur_mask, pick_oh, rest_mask;
  logic [SL_W-1:0]          pick_idx;
  ts_t                      pick_ts;
  amp_t                     pick_amp;
  logic                     last_strip;

  tsb_tsgen #(.TICK_DIV(TICK_DIV)) u_tsgen (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .ts_tick(ts_tick)
  );

  tsb_trigq #(.DEPTH(TQ_DEPTH)) u_trigq (
    .clk(clk), .rst_n(rst_n), .push(trig_vld), .push_ts(trig_ts),
    .pop(tq_pop), .empty(tq_empty), .head_ts(tq_head)
  );

  for (genvar s = 0; s < NSTRIP; s++) begin : g_strip
    tsb_strip #(.DEPTH(DEPTH), .AGE_LIM(AGE_LIM)) u_strip (
      .clk(clk), .rst_n(rst_n),
      .hit_in(hit_vld[s]), .amp_in(hit_amp[s*AMP_W +: AMP_W]),
      .ts_now(ts_now), .sel_ts(sel_ts), .win(cfg_win),
      .hit_match(mask_a[s]), .ent_ts_flat(ts_a[s]), .ent_amp_flat(amp_a[s]),
      .drop(drop_v[s])
    );
  end

  // sparsifier: lowest matching slot of the strip under the cursor
  always_comb begin
    cur_mask = mask_a[strip_q] & ~done_q;
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cur_mask[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
        pick_idx   = SL_W'(i);
      end
    end
    rest_mask  = cur_mask & ~pick_oh;
    pick_ts    = ts_a[strip_q][pick_idx*TS_W +: TS_W];
    pick_amp   = amp_a[strip_q][pick_idx*AMP_W +: AMP_W];
    last_strip = (strip_q == SA_W'(NSTRIP - 1));
  end

  assign tq_pop = (state_q == S_IDLE) && !tq_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      strip_q  <= '0;
      done_q   <= '0;
      sel_ts   <= '0;
      out_vld  <= 1'b0;
      out_eoe  <= 1'b0;
      out_word <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= overflow | (|drop_v);
      out_vld  <= 1'b0;
      out_eoe  <= 1'b0;
      case (state_q)
        S_IDLE: if (tq_pop) begin
          sel_ts  <= tq_head;
          strip_q <= '0;
          done_q  <= '0;
          state_q <= S_SCAN;
        end
        S_SCAN: begin
          if (|cur_mask) begin
            out_vld  <= 1'b1;
            out_word <= {strip_q, pick_ts, pick_amp};
            done_q   <= done_q | pick_oh;
          end
          if (rest_mask == '0) begin
            done_q <= '0;
            if (last_strip) state_q <= S_EOE;
            else            strip_q <= strip_q + SA_W'(1);
          end
        end
        default: begin
          out_vld  <= 1'b1;
          out_eoe  <= 1'b1;
          out_word <= {SA_W'(0), sel_ts, AMP_W'(0)};
          state_q  <= S_IDLE;
        end
      endcase
    end
  end

  p_eoe_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |-> out_vld);
  p_word_in_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_eoe) |-> in_window(sel_ts, out_word[AMP_W +: TS_W], cfg_win));
  p_strip_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_eoe && $past(out_vld && !out_eoe))
      |-> out_word[TS_W+AMP_W +: SA_W] >= $past(out_word[TS_W+AMP_W +: SA_W]));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/tsb_top_bench.sv
module tsb_top_bench;
  localparam int NS = 128, DP = 4, TW = 9, AW = 4, WW = 20, TD = 2, AL = 330;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   hit_vld = '0;
  logic [NS*AW-1:0] hit_amp = '0;
  logic [TW-1:0]   cfg_win = 9'd10;
  logic            trig_vld = 1'b0;
  logic [TW-1:0]   trig_ts = '0;
  logic [TW-1:0]   ts_now;
  logic            out_vld, out_eoe, overflow;
  logic [WW-1:0]   out_word;

  always #2 clk = ~clk;

  tsb_top u_tsb_top (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_amp(hit_amp),
    .cfg_win(cfg_win), .trig_vld(trig_vld), .trig_ts(trig_ts),
    .ts_now(ts_now), .out_vld(out_vld), .out_eoe(out_eoe),
    .out_word(out_word), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  bit            mv   [NS][DP];
  logic [TW-1:0] mts  [NS][DP];
  logic [AW-1:0] mamp [NS][DP];
  logic [WW:0]   exp_q[$];
  logic [WW:0]   got_q[$];

  always @(negedge clk) if (rst_n && out_vld) got_q.push_back({out_eoe, out_word});

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit win_hit(logic [TW-1:0] t, logic [TW-1:0] h, logic [TW-1:0] w);
    logic [TW-1:0] d = t - h;
    return d < w;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NS; s++) for (int e = 0; e < DP; e++) mv[s][e] = 0;
  endtask

  // drive at falling edge; hit stored at next rising edge with current ts
  task automatic apply_hits(logic [NS-1:0] m, logic [NS*AW-1:0] a);
    hit_vld = m;
    hit_amp = a;
    for (int s = 0; s < NS; s++) if (m[s]) begin
      for (int e = 0; e < DP; e++) if (!mv[s][e]) begin
        mv[s][e] = 1; mts[s][e] = ts_now; mamp[s][e] = a[s*AW +: AW];
        break;
      end
    end
    @(negedge clk);
    hit_vld = '0;
  endtask

  task automatic send_trig(logic [TW-1:0] t);
    trig_vld = 1'b1;
    trig_ts  = t;
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < DP; e++)
        if (mv[s][e] && win_hit(t, mts[s][e], cfg_win))
          exp_q.push_back({1'b0, 7'(s), mts[s][e], mamp[s][e]});
    exp_q.push_back({1'b1, 7'd0, t, 4'd0});
    @(negedge clk);
    trig_vld = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 4000 && got_q.size() < exp_q.size(); i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got_q.size()) chk(got_q[i] === exp_q[i], tag, 32'(got_q[i]), 32'(exp_q[i]));
    end
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic age_out();
    repeat ((AL + 6) * TD) @(negedge clk);
    model_clear();
  endtask

  function automatic logic [NS*AW-1:0] rnd_amp();
    logic [NS*AW-1:0] a;
    for (int s = 0; s < NS; s++) a[s*AW +: AW] = AW'($urandom);
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] a_ts, b_ts, c_ts, t0;
    logic [NS-1:0] m;
    logic [NS*AW-1:0] amps;
    void'($urandom(32'd4242));
    model_clear();
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!out_vld && !out_eoe && !overflow && ts_now == 0, "R1 during reset",
        {out_vld, out_eoe, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && !overflow && ts_now == 0, "R1 after reset", {out_vld, overflow, ts_now}, 0);

    // R2: tick rate and wrap
    t0 = ts_now;
    repeat (10 * TD) @(negedge clk);
    chk(ts_now == t0 + 9'd10, "R2 rate", ts_now, t0 + 9'd10);
    t0 = ts_now;
    repeat (512 * TD) @(negedge clk);
    chk(ts_now == t0, "R2 wrap", ts_now, t0);

    // R5: empty event still gives a marker; R3 nothing without trigger
    repeat (20) @(negedge clk);
    chk(got_q.size() == 0, "R3 no trigger no output", got_q.size(), 0);
    send_trig(ts_now);
    drain("R5 empty event");

    // directed window / overlap / queue order
    m = '0; m[0] = 1; m[5] = 1; m[127] = 1;
    a_ts = ts_now;
    apply_hits(m, rnd_amp());
    repeat (13 * TD) @(negedge clk);
    m = '0; m[5] = 1;
    b_ts = ts_now;
    apply_hits(m, rnd_amp());
    repeat (13 * TD) @(negedge clk);
    c_ts = ts_now;
    apply_hits(m, rnd_amp());
    repeat (4) @(negedge clk);
    send_trig(a_ts + 9'd5);   // R9: first overlap
    send_trig(a_ts + 9'd9);   // R9: second overlap, same hits again
    send_trig(b_ts + 9'd3);   // R3: only the middle hit
    send_trig(c_ts);          // R6: fourth queued trigger
    drain("R3/R4/R6/R9/R10 directed");

    // R7: after aging, hits vanish and slots are free again
    age_out();
    send_trig(a_ts + 9'd5);
    drain("R7 purged hits not sent");
    m = '0; m[5] = 1;
    for (int k = 0; k < DP; k++) apply_hits(m, {NS{4'(k + 1)}});
    chk(!overflow, "R7 freed slots reused", overflow, 0);

    // R8: fifth hit on strip 5 is dropped
    apply_hits(m, {NS{4'hF}});
    chk(overflow, "R8 overflow set", overflow, 1);
    send_trig(ts_now);
    drain("R8 dropped hit absent");
    repeat (50) @(negedge clk);
    chk(overflow, "R8 overflow sticky", overflow, 1);
    age_out();

    // constrained random rounds
    for (int r = 0; r < 6; r++) begin
      cfg_win = 9'(4 + $urandom % 17);
      for (int c = 0; c < 20; c++) begin
        m = '0;
        for (int s = 0; s < NS; s++) if ($urandom % 32 == 0 && !mv[s][DP-1]) m[s] = 1;
        amps = rnd_amp();
        apply_hits(m, amps);
      end
      for (int k = 0; k < 3; k++) send_trig(ts_now - 9'($urandom % 25));
      drain("R3/R4/R10 random");
      age_out();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule